// File: doc/BRIEF.md
# Gain-Segment Output Range Combiner

The combiner takes a 10-bit unsigned converter sample captured at one of four analog gain settings and produces one 13-bit code. The gain setting is given with each sample as a 2-bit segment code. The block multiplies the sample by a power of two chosen by the segment. For every segment except the highest-gain one, it then adds a signed, pre-scaled calibration correction. The result is a single monotonic scale that covers all four gain ranges without steps at the range boundaries.

The three corrections are 8-bit two's-complement values held in a small register bank. A calibration engine loads them through a dedicated write port once its algorithm has finished. A host can only read them back, one cycle after a read strobe. There is no host write path, so the corrections cannot be disturbed by software. Samples flow as a valid/data stream through one register stage. A result that falls outside 0..8191 is clamped, and a per-sample flag marks that it was clamped.

Top module: `gain_seg_combiner`

## Requirements
- R1: While reset is high and after its release, out_valid, out_code, out_sat and host_rdata are 0, and all three correction registers read 00h.
- R2: Segment code 00 (8x) outputs the sample unchanged, with out_sat low and no correction applied.
- R3: Segment code 01 (4x) outputs 2*sample + c1. Here c1 is the sign-extended correction held at address 0Eh.
- R4: Segment code 10 (2x) outputs 4*sample + 2*c2. Here c2 is the sign-extended correction at address 0Fh.
- R5: Segment code 11 (1x) outputs 8*sample + 4*c3. Here c3 is the sign-extended correction at address 10h.
- R6: A result below 0 is output as 0 and a result above 8191 is output as 8191, with out_sat high for that sample. Otherwise out_sat is low.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. While in_valid is low, out_code and out_sat keep their last values.
- R8: A calibration write with cal_wr high loads cal_wdata into the register at cal_addr (0Eh, 0Fh or 10h), and samples presented from the next cycle on use the new value. Writes to any other address change nothing. The corrections change only through this port.
- R9: A read strobe host_rd returns, on host_rdata in the following cycle, the correction at host_addr. Any address outside 0Eh..10h returns 00h. Without a strobe, host_rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 10 | Unsigned converter sample |
| in_seg | input | 2 | Gain segment: 00=8x, 01=4x, 10=2x, 11=1x |
| out_valid | output | 1 | Combined code valid |
| out_code | output | 13 | Combined monotonic code |
| out_sat | output | 1 | Code was clamped to 0 or 8191 |
| cal_wr | input | 1 | Calibration engine write strobe |
| cal_addr | input | 8 | Calibration write address |
| cal_wdata | input | 8 | Correction value, two's complement |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host read address |
| host_rdata | output | 8 | Read data, valid the cycle after the strobe |

## Verification
The hardest conditions to reach are the clamp edges. Those are the 1x segment near full scale with a large positive correction, and the lowest samples of the 4x, 2x and 1x segments with a negative one. Both only arise once the calibration port holds extreme values. The bench therefore loads several correction sets through the calibration port, including +127 and -128 in every register and a mixed set. After each load it sweeps every sample in every segment, so that each overflow and underflow boundary is crossed and compared against arithmetic computed in the bench.

// File: rtl/gsc_pkg.sv
`timescale 1ns/1ps
package gsc_pkg;
    localparam int SAMPLE_W = 10;
    localparam int CODE_W   = 13;
    localparam int OFS_W    = 8;
    localparam int NSEG     = 4;
    localparam int NOFS     = NSEG - 1;
    localparam int ADDR_W   = 8;
    localparam int SUM_W    = CODE_W + 2;
    localparam int SEG_W    = $clog2(NSEG);

    localparam logic [ADDR_W-1:0] OFS_BASE = 8'h0E;
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'((1 << CODE_W) - 1);

    typedef enum logic [SEG_W-1:0] {
        SEG_X8 = 2'd0,
        SEG_X4 = 2'd1,
        SEG_X2 = 2'd2,
        SEG_X1 = 2'd3
    } seg_e;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  sat;
        code_t code;
    } result_t;

    function automatic logic [ADDR_W-1:0] ofs_addr(input int k);
        return OFS_BASE + ADDR_W'(k);
    endfunction

    function automatic logic signed [SUM_W-1:0] sext_ofs(input logic [OFS_W-1:0] o);
        return $signed({{(SUM_W-OFS_W){o[OFS_W-1]}}, o});
    endfunction

    function automatic result_t clamp(input logic signed [SUM_W-1:0] v);
        result_t r;
        if (v < 0) begin
            r.sat  = 1'b1;
            r.code = '0;
        end else if (v > SUM_MAX) begin
            r.sat  = 1'b1;
            r.code = '1;
        end else begin
            r.sat  = 1'b0;
            r.code = v[CODE_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/gsc_offset_bank.sv
`timescale 1ns/1ps
module gsc_offset_bank
    import gsc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cal_wr,
    input  logic [ADDR_W-1:0]      cal_addr,
    input  logic [OFS_W-1:0]       cal_wdata,
    input  logic                   host_rd,
    input  logic [ADDR_W-1:0]      host_addr,
    output logic [OFS_W-1:0]       host_rdata,
    output logic [NOFS*OFS_W-1:0]  ofs_flat
);
    logic [OFS_W-1:0] ofs_q [NOFS];
    logic [OFS_W-1:0] rd_mux;

    genvar k;
    generate
        for (k = 0; k < NOFS; k++) begin : g_reg
            localparam logic [ADDR_W-1:0] MY_ADDR = ofs_addr(k);
            always_ff @(posedge clk) begin
                if (rst) begin
                    ofs_q[k] <= '0;
                end else if (cal_wr && (cal_addr == MY_ADDR)) begin
                    ofs_q[k] <= cal_wdata;
                end
            end
            assign ofs_flat[k*OFS_W +: OFS_W] = ofs_q[k];
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NOFS; i++) begin
            if (host_addr == ofs_addr(i)) begin
                rd_mux = ofs_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gsc_scaler.sv
`timescale 1ns/1ps
module gsc_scaler
    import gsc_pkg::*;
(
    input  logic [SAMPLE_W-1:0]    sample,
    input  seg_e                   seg,
    input  logic [NOFS*OFS_W-1:0]  ofs_flat,
    output result_t                res
);
    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] cand [NSEG];

    assign base = $signed({{(SUM_W-SAMPLE_W){1'b0}}, sample});

    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_seg
            if (g == 0) begin : g_pass
                assign cand[g] = base;
            end else begin : g_corr
                assign cand[g] = (base <<< g)
                               + (sext_ofs(ofs_flat[(g-1)*OFS_W +: OFS_W]) <<< (g-1));
            end
        end
    endgenerate

    assign res = clamp(cand[seg]);
endmodule

// File: rtl/gsc_out_stage.sv
`timescale 1ns/1ps
module gsc_out_stage
    import gsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  result_t  res_d,
    output logic     out_valid,
    output code_t    out_code,
    output logic     out_sat
);
    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_code = res_q.code;
    assign out_sat  = res_q.sat;
endmodule

// File: rtl/gain_seg_combiner.sv
`timescale 1ns/1ps
module gain_seg_combiner
    import gsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_sample,
    input  logic [SEG_W-1:0]     in_seg,
    output logic                 out_valid,
    output logic [CODE_W-1:0]    out_code,
    output logic                 out_sat,
    input  logic                 cal_wr,
    input  logic [ADDR_W-1:0]    cal_addr,
    input  logic [OFS_W-1:0]     cal_wdata,
    input  logic                 host_rd,
    input  logic [ADDR_W-1:0]    host_addr,
    output logic [OFS_W-1:0]     host_rdata
);
    logic [NOFS*OFS_W-1:0] ofs_flat;
    result_t               res_d;

    gsc_offset_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .cal_wr     (cal_wr),
        .cal_addr   (cal_addr),
        .cal_wdata  (cal_wdata),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_rdata (host_rdata),
        .ofs_flat   (ofs_flat)
    );

    gsc_scaler u_scale (
        .sample   (in_sample),
        .seg      (seg_e'(in_seg)),
        .ofs_flat (ofs_flat),
        .res      (res_d)
    );

    gsc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res_d     (res_d),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_sat   (out_sat)
    );
endmodule

// File: rtl/gsc_checker.sv
`timescale 1ns/1ps
module gsc_checker
    import gsc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [SAMPLE_W-1:0]  in_sample,
    input logic [SEG_W-1:0]     in_seg,
    input logic                 out_valid,
    input logic [CODE_W-1:0]    out_code,
    input logic                 out_sat,
    input logic                 cal_wr,
    input logic                 host_rd,
    input logic [OFS_W-1:0]     host_rdata,
    input logic [NOFS*OFS_W-1:0] ofs_flat
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_code) && $stable(out_sat))); // R7
    AST_X8_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && in_seg == 2'd0) |=> (out_code == {{(CODE_W-SAMPLE_W){1'b0}}, $past(in_sample)} && !out_sat)); // R2
    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst) out_sat |-> (out_code == '0 || out_code == '1)); // R6
    AST_OFS_CAL_ONLY: assert property (@(posedge clk) disable iff (rst) !cal_wr |=> $stable(ofs_flat)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !host_rd |=> $stable(host_rdata)); // R9
endmodule

bind gain_seg_combiner gsc_checker u_chk (.*);

// File: tb/gain_seg_combiner_test.sv
`timescale 1ns/1ps
module gain_seg_combiner_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [9:0]  in_sample;
    logic [1:0]  in_seg;
    logic        out_valid;
    logic [12:0] out_code;
    logic        out_sat;
    logic        cal_wr;
    logic [7:0]  cal_addr;
    logic [7:0]  cal_wdata;
    logic        host_rd;
    logic [7:0]  host_addr;
    logic [7:0]  host_rdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gain_seg_combiner uut (.*);

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int raw_val(input int s, input int seg, input int c1, input int c2, input int c3);
        case (seg)
            0:       return s;
            1:       return 2*s + c1;
            2:       return 4*s + 2*c2;
            default: return 8*s + 4*c3;
        endcase
    endfunction

    function automatic int clip(input int v);
        if (v < 0) return 0;
        if (v > 8191) return 8191;
        return v;
    endfunction

    task automatic cal_write(input int addr, input int data);
        @(negedge clk);
        cal_wr    = 1'b1;
        cal_addr  = 8'(addr);
        cal_wdata = 8'(data);
        @(negedge clk);
        cal_wr    = 1'b0;
    endtask

    task automatic host_read(input int addr, input int exp, input string tag);
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = 8'(addr);
        @(posedge clk);
        #1;
        check(tag, int'(host_rdata), exp);
        @(negedge clk);
        host_rd   = 1'b0;
    endtask

    task automatic present(input int s, input int seg);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 10'(s);
        in_seg    = 2'(seg);
        @(posedge clk);
        #1;
    endtask

    task automatic sweep(input int c1, input int c2, input int c3);
        string tg [4] = '{"R2", "R3", "R4", "R5"};
        cal_write(8'h0E, c1);
        cal_write(8'h0F, c2);
        cal_write(8'h10, c3);
        for (int seg = 0; seg < 4; seg++) begin
            for (int s = 0; s < 1024; s++) begin
                int v;
                v = raw_val(s, seg, c1, c2, c3);
                present(s, seg);
                check("R7 valid", int'(out_valid), 1);
                check(tg[seg], int'(out_code), clip(v));
                check("R6 sat", int'(out_sat), (v < 0 || v > 8191) ? 1 : 0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_sample = 0; in_seg = 0;
        cal_wr = 0; cal_addr = 0; cal_wdata = 0; host_rd = 0; host_addr = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_code", int'(out_code), 0);
        check("R1 out_sat", int'(out_sat), 0);
        check("R1 host_rdata", int'(host_rdata), 0);
        rst = 1'b0;
        host_read(8'h0E, 0, "R1 ofs1");
        host_read(8'h0F, 0, "R1 ofs2");
        host_read(8'h10, 0, "R1 ofs3");

        // R8: correction takes effect for a sample presented right after the write
        cal_write(8'h0E, 10);
        present(100, 1);
        check("R8 new ofs used", int'(out_code), 210);

        // R7: idle cycle drops valid and holds code
        @(negedge clk);
        in_valid = 1'b0; in_sample = 10'd5; in_seg = 2'd3;
        @(posedge clk); #1;
        check("R7 idle valid", int'(out_valid), 0);
        check("R7 idle hold", int'(out_code), 210);
        @(posedge clk); #1;
        check("R7 idle hold2", int'(out_code), 210);

        // R9: reads of each register, unmapped address, hold without strobe
        cal_write(8'h0F, 8'hF3);
        cal_write(8'h10, 8'h40);
        host_read(8'h0E, 10, "R9 rd 0E");
        host_read(8'h0F, 8'hF3, "R9 rd 0F");
        host_read(8'h10, 8'h40, "R9 rd 10");
        host_read(8'h0D, 0, "R9 rd unmapped");
        host_read(8'h10, 8'h40, "R9 rd 10 again");
        @(negedge clk); host_addr = 8'h0E;
        @(posedge clk); #1;
        check("R9 hold no strobe", int'(host_rdata), 8'h40);

        // R8: writes outside the map change nothing
        cal_write(8'h11, 8'h55);
        cal_write(8'h0D, 8'h66);
        host_read(8'h0E, 10, "R8 ignore 0E");
        host_read(8'h0F, 8'hF3, "R8 ignore 0F");
        host_read(8'h10, 8'h40, "R8 ignore 10");
        host_read(8'h11, 0, "R8 ignore 11");

        sweep(0, 0, 0);
        sweep(127, 127, 127);
        sweep(-128, -128, -128);
        sweep(5, -3, 64);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule